// File: doc/BRIEF.md
# Transfer Counter and Status Flags

This unit keeps the books for one serial transfer in a serial core. Software programs a bits-per-word value, a counting mode for each direction, and the number of words to move. The unit then watches the strobes that push words into and pop words out of the input and output FIFOs, together with the occupancy that each FIFO reports. From these it raises sticky service and completion flags, live full/not-empty bits, and sticky overrun/underrun error flags. The three sticky sets are cleared by writing ones, and a single interrupt line combines them through an error-enable register and a service/done mask.

There are two counting modes for each direction. FIFO mode takes its target from a pair of small-transfer count registers, and block mode takes it from a separate pair. Only the pair that belongs to the current mode has any effect. The unit also reports how many bytes one word occupies and right-justifies a raw received word to the programmed width. The FIFO storage and the shift register lie outside this block.

Top module: `xfer_stat_top`

## Requirements
- R1: The config register (address 0) holds bits-per-word minus one in bits 4:0. `word_bytes` reads 1 when bits-per-word is at most 8, 2 when it is at most 16, and 4 otherwise, for widths 4 to 32.
- R2: `rx_word` equals `rx_raw` with every bit at or above bits-per-word forced to zero, so the word is right-justified.
- R3: The mode register (address 1) holds the input mode in bits 13:12 and the output mode in bits 11:10, with code 0 for FIFO and 1 for block. FIFO mode takes its target from address 2 (input) and address 3 (output). Block mode takes it from address 4 (input) and address 5 (output). The count register of the other mode has no effect, and codes 2 and 3 never complete.
- R4: Input-done (op bit 11) sets at the clock edge at which the number of pushes accepted into the non-full input FIFO reaches a non-zero target. Output-done (op bit 10) does the same for pops taken from the non-empty output FIFO. A write to any address from 1 to 5 restarts both counts.
- R5: In block mode, input-service (op bit 9) and output-service (op bit 8) set each time another block of BLK counted words completes. BLK is 4 when the block code is 0 and the code times 16 otherwise; the default is 4.
- R6: In FIFO mode, input-service sets on every accepted input push. Output-service sets on a pop that empties the output FIFO, meaning the level was 1.
- R7: Live op bits follow the level inputs. Bit 7 is input full, bit 6 is output full, bit 5 is input not-empty and bit 4 is output not-empty. Depth is BLK times (2 shifted left by the FIFO code); the default is 8.
- R8: Sticky error bits: bit 5 is a push to a full output FIFO, bit 4 is a pop from an empty input FIFO, bit 3 is a pop from an empty output FIFO, and bit 2 is a push to a full input FIFO. A rejected strobe is not counted. The serial strobes set `ser_flags` bit 1 (clock overrun) and bit 0 (clock underrun).
- R9: A write of ones to address 6 (op bits 11:8), 7 (error) or 8 (serial) clears exactly those bits. Zero bits are left alone, and a set at the same edge wins over the clear.
- R10: `irq` is high whenever an op bit 11:8 is set and not masked by the same bit of address 10. It is also high when an error bit 5:2 or serial bit 1:0 is set and the same bit of the enable register (address 9) is set.
- R11: After reset all flags, counts and configuration are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| in_push | input | 1 | Shifter writes a word into the input FIFO |
| in_pop | input | 1 | Host reads a word from the input FIFO |
| out_push | input | 1 | Host writes a word into the output FIFO |
| out_pop | input | 1 | Shifter takes a word from the output FIFO |
| in_level | input | LVL_W | Input FIFO occupancy |
| out_level | input | LVL_W | Output FIFO occupancy |
| sclk_over | input | 1 | Serial clock overrun strobe |
| sclk_under | input | 1 | Serial clock underrun strobe |
| rx_raw | input | 32 | Raw received word |
| op_flags | output | 16 | Operational flags |
| err_flags | output | 8 | FIFO error flags |
| ser_flags | output | 2 | Serial clock error flags |
| word_bytes | output | 3 | Bytes per word |
| rx_word | output | 32 | Right-justified received word |
| irq | output | 1 | Interrupt |

## Verification
The hardest situations to reach are the collisions: a clearing write that lands on the same edge as a new error, and strobes that arrive while the FIFO is already full or empty. The bench reaches them by keeping its own occupancy model. It drives that model up to depth and then issues one more strobe, sometimes in the same cycle as a clear. The mode-exclusivity checks program the unused count register to a small value that would otherwise complete first, then confirm that completion comes only at the selected target.

// File: rtl/xfer_stat_pkg.sv
package xfer_stat_pkg;
  typedef enum logic [1:0] {
    XM_FIFO  = 2'd0,
    XM_BLOCK = 2'd1,
    XM_RSV2  = 2'd2,
    XM_RSV3  = 2'd3
  } xfer_mode_e;

  localparam logic [3:0] A_CFG    = 4'd0;
  localparam logic [3:0] A_MODE   = 4'd1;
  localparam logic [3:0] A_FRD    = 4'd2;
  localparam logic [3:0] A_FWR    = 4'd3;
  localparam logic [3:0] A_BIN    = 4'd4;
  localparam logic [3:0] A_BOUT   = 4'd5;
  localparam logic [3:0] A_OPCLR  = 4'd6;
  localparam logic [3:0] A_ERRCLR = 4'd7;
  localparam logic [3:0] A_SERCLR = 4'd8;
  localparam logic [3:0] A_ERREN  = 4'd9;
  localparam logic [3:0] A_OPMSK  = 4'd10;

  // Byte footprint of one word from the (bits-per-word - 1) field.
  function automatic logic [2:0] bytes_for_n(input logic [4:0] n);
    if (n <= 5'd7)       return 3'd1;
    else if (n <= 5'd15) return 3'd2;
    else                 return 3'd4;
  endfunction
endpackage

// File: rtl/xfer_word_fmt.sv
module xfer_word_fmt
  import xfer_stat_pkg::*;
(
  input  logic [4:0]  nfield,
  input  logic [31:0] raw,
  output logic [2:0]  word_bytes,
  output logic [31:0] justified
);
  logic [5:0]  bpw;
  logic [32:0] keep;

  always_comb begin
    bpw        = {1'b0, nfield} + 6'd1;
    keep       = (33'd1 << bpw) - 33'd1;
    word_bytes = bytes_for_n(nfield);
    justified  = raw & keep[31:0];
  end

  always_comb begin
    assert_bytes_code_R1: assert ($countones(word_bytes) == 1);
  end
endmodule

// File: rtl/xfer_side.sv
module xfer_side
  import xfer_stat_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 8,
  parameter int BLK      = 4,
  parameter int LVL_W    = 4,
  parameter bit IS_INPUT = 1'b1,
  localparam int BW      = (BLK > 1) ? $clog2(BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] fifo_tgt,
  input  logic [CNT_W-1:0] blk_tgt,
  input  logic             fill,
  input  logic             drain,
  input  logic [LVL_W-1:0] level,
  output logic             done_hit,
  output logic             svc_hit,
  output logic             over_hit,
  output logic             under_hit,
  output logic             full,
  output logic             not_empty
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]    blk_q, blk_d;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W:0]   cnt_inc;
  logic             fill_ok, drain_ok, cnt_ev, fifo_svc, blk_wrap;

  always_comb begin
    full      = (level == LVL_W'(DEPTH));
    not_empty = (level != '0);
    over_hit  = fill && full;
    under_hit = drain && !not_empty;
    fill_ok   = fill && !full;
    drain_ok  = drain && not_empty;
  end

  if (IS_INPUT) begin : g_in
    assign cnt_ev   = fill_ok;
    assign fifo_svc = fill_ok;
  end else begin : g_out
    assign cnt_ev   = drain_ok;
    assign fifo_svc = drain_ok && (level == LVL_W'(1));
  end

  always_comb begin
    case (xfer_mode_e'(mode))
      XM_FIFO:  tgt = fifo_tgt;
      XM_BLOCK: tgt = blk_tgt;
      default:  tgt = '0;
    endcase
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    blk_wrap = (blk_q == BW'(BLK - 1));
    done_hit = cnt_ev && (tgt != '0) && (cnt_inc == {1'b0, tgt});
    case (xfer_mode_e'(mode))
      XM_FIFO:  svc_hit = fifo_svc;
      XM_BLOCK: svc_hit = cnt_ev && blk_wrap;
      default:  svc_hit = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blk_q;
    if (restart) begin
      cnt_d = '0;
      blk_d = '0;
    end else if (cnt_ev) begin
      if (cnt_q != '1) cnt_d = cnt_inc[CNT_W-1:0];
      blk_d = blk_wrap ? '0 : blk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assert_blk_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q <= BW'(BLK - 1));
endmodule

// File: rtl/xfer_stat_top.sv
module xfer_stat_top
  import xfer_stat_pkg::*;
#(
  parameter int BLK_CODE  = 0,
  parameter int FIFO_CODE = 0,
  parameter int CNT_W     = 16,
  localparam int BLK      = (BLK_CODE == 0) ? 4 : BLK_CODE * 16,
  localparam int DEPTH    = BLK * (2 << FIFO_CODE),
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             in_push,
  input  logic             in_pop,
  input  logic             out_push,
  input  logic             out_pop,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  input  logic             sclk_over,
  input  logic             sclk_under,
  input  logic [31:0]      rx_raw,
  output logic [15:0]      op_flags,
  output logic [7:0]       err_flags,
  output logic [1:0]       ser_flags,
  output logic [2:0]       word_bytes,
  output logic [31:0]      rx_word,
  output logic             irq
);
  // configuration
  logic [4:0]       n_q, n_d;
  logic [1:0]       imode_q, imode_d, omode_q, omode_d;
  logic [CNT_W-1:0] frd_q, frd_d, fwr_q, fwr_d, bin_q, bin_d, bout_q, bout_d;
  logic [5:0]       en_q, en_d;
  logic [3:0]       msk_q, msk_d;
  // sticky flags: op {in done, out done, in svc, out svc}
  // err {out over, in under, out under, in over}
  logic [3:0]       op_q, op_d, err_q, err_d;
  logic [1:0]       ser_q, ser_d;
  logic             restart;

  // per-direction trackers, index 0 = output, 1 = input
  logic [1:0]       fill_a, drain_a, done_a, svc_a, over_a, under_a, full_a, ne_a;
  logic [1:0]       mode_a [2];
  logic [LVL_W-1:0] lvl_a [2];
  logic [CNT_W-1:0] ftgt_a [2];
  logic [CNT_W-1:0] btgt_a [2];

  assign fill_a    = {in_push, out_push};
  assign drain_a   = {in_pop, out_pop};
  assign mode_a[0] = omode_q;
  assign mode_a[1] = imode_q;
  assign lvl_a[0]  = out_level;
  assign lvl_a[1]  = in_level;
  assign ftgt_a[0] = fwr_q;
  assign ftgt_a[1] = frd_q;
  assign btgt_a[0] = bout_q;
  assign btgt_a[1] = bin_q;

  for (genvar g = 0; g < 2; g++) begin : g_side
    xfer_side #(
      .CNT_W(CNT_W), .DEPTH(DEPTH), .BLK(BLK), .LVL_W(LVL_W),
      .IS_INPUT(g == 1)
    ) u_side (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .mode(mode_a[g]), .fifo_tgt(ftgt_a[g]), .blk_tgt(btgt_a[g]),
      .fill(fill_a[g]), .drain(drain_a[g]), .level(lvl_a[g]),
      .done_hit(done_a[g]), .svc_hit(svc_a[g]),
      .over_hit(over_a[g]), .under_hit(under_a[g]),
      .full(full_a[g]), .not_empty(ne_a[g])
    );
  end

  xfer_word_fmt u_fmt (
    .nfield(n_q), .raw(rx_raw), .word_bytes(word_bytes), .justified(rx_word)
  );

  // next state
  always_comb begin
    n_d = n_q;  imode_d = imode_q;  omode_d = omode_q;
    frd_d = frd_q;  fwr_d = fwr_q;  bin_d = bin_q;  bout_d = bout_q;
    en_d = en_q;  msk_d = msk_q;
    restart = 1'b0;
    op_d  = op_q  | {done_a[1], done_a[0], svc_a[1], svc_a[0]};
    err_d = err_q | {over_a[0], under_a[1], under_a[0], over_a[1]};
    ser_d = ser_q | {sclk_over, sclk_under};
    if (wr_en) begin
      case (wr_addr)
        A_CFG:    n_d = wr_data[4:0];
        A_MODE:   begin imode_d = wr_data[13:12]; omode_d = wr_data[11:10]; restart = 1'b1; end
        A_FRD:    begin frd_d  = wr_data[CNT_W-1:0]; restart = 1'b1; end
        A_FWR:    begin fwr_d  = wr_data[CNT_W-1:0]; restart = 1'b1; end
        A_BIN:    begin bin_d  = wr_data[CNT_W-1:0]; restart = 1'b1; end
        A_BOUT:   begin bout_d = wr_data[CNT_W-1:0]; restart = 1'b1; end
        A_OPCLR:  op_d  = (op_q & ~wr_data[11:8]) | {done_a[1], done_a[0], svc_a[1], svc_a[0]};
        A_ERRCLR: err_d = (err_q & ~wr_data[5:2]) | {over_a[0], under_a[1], under_a[0], over_a[1]};
        A_SERCLR: ser_d = (ser_q & ~wr_data[1:0]) | {sclk_over, sclk_under};
        A_ERREN:  en_d  = wr_data[5:0];
        A_OPMSK:  msk_d = wr_data[11:8];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;  imode_q <= '0;  omode_q <= '0;
      frd_q <= '0;  fwr_q <= '0;  bin_q <= '0;  bout_q <= '0;
      en_q <= '0;  msk_q <= '0;
      op_q <= '0;  err_q <= '0;  ser_q <= '0;
    end else begin
      n_q <= n_d;  imode_q <= imode_d;  omode_q <= omode_d;
      frd_q <= frd_d;  fwr_q <= fwr_d;  bin_q <= bin_d;  bout_q <= bout_d;
      en_q <= en_d;  msk_q <= msk_d;
      op_q <= op_d;  err_q <= err_d;  ser_q <= ser_d;
    end
  end

  assign op_flags  = {4'b0, op_q, full_a[1], full_a[0], ne_a[1], ne_a[0], 4'b0};
  assign err_flags = {2'b0, err_q, 2'b0};
  assign ser_flags = ser_q;
  assign irq = |(op_q & ~msk_q) | |(err_q & en_q[5:2]) | |(ser_q & en_q[1:0]);

  assert_in_done_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_q[3]) |-> $past(in_push));
  assert_in_over_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q[0]) |-> $past(in_push && in_level == LVL_W'(DEPTH)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_addr == A_ERRCLR) |-> ((err_q & $past(err_q)) == $past(err_q)));
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == '0 && err_q == '0 && ser_q == '0) |-> !irq);
endmodule

// File: tb/sim_xfer_stat_top.sv
module sim_xfer_stat_top;
  localparam int TCLK  = 10;
  localparam int DEPTH = 8;

  logic        clk, rst_n, wr_en, in_push, in_pop, out_push, out_pop;
  logic        sclk_over, sclk_under, irq;
  logic [3:0]  wr_addr, in_level, out_level;
  logic [31:0] wr_data, rx_raw, rx_word;
  logic [15:0] op_flags;
  logic [7:0]  err_flags;
  logic [1:0]  ser_flags;
  logic [2:0]  word_bytes;
  int checks = 0, errors = 0, in_lvl = 0, out_lvl = 0;
  bit finished = 0;

  xfer_stat_top u0 (.*);

  initial clk = 0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycw(input bit ip, ipo, opu, opo, so, su, we,
                      input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    in_push = ip; in_pop = ipo; out_push = opu; out_pop = opo;
    sclk_over = so; sclk_under = su; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    in_lvl  = in_lvl  + ((ip  && in_lvl  < DEPTH) ? 1 : 0) - ((ipo && in_lvl  > 0) ? 1 : 0);
    out_lvl = out_lvl + ((opu && out_lvl < DEPTH) ? 1 : 0) - ((opo && out_lvl > 0) ? 1 : 0);
    in_push = 0; in_pop = 0; out_push = 0; out_pop = 0;
    sclk_over = 0; sclk_under = 0; wr_en = 0;
    in_level = in_lvl[3:0]; out_level = out_lvl[3:0];
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cycw(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask
  task automatic ipush(); cycw(1, 0, 0, 0, 0, 0, 0, 4'd0, 32'd0); endtask
  task automatic ipop();  cycw(0, 1, 0, 0, 0, 0, 0, 4'd0, 32'd0); endtask
  task automatic opush(); cycw(0, 0, 1, 0, 0, 0, 0, 4'd0, 32'd0); endtask
  task automatic opop();  cycw(0, 0, 0, 1, 0, 0, 0, 4'd0, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    in_push = 0; in_pop = 0; out_push = 0; out_pop = 0;
    sclk_over = 0; sclk_under = 0; in_level = 0; out_level = 0;
    rx_raw = 32'hA5C3_96E1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk("R11 op", {16'b0, op_flags}, 32'd0);
    chk("R11 err", {24'b0, err_flags}, 32'd0);
    chk("R11 ser", {30'b0, ser_flags}, 32'd0);
    chk("R11 irq", {31'b0, irq}, 32'd0);

    // R1 R2: sweep every supported width
    for (int b = 4; b <= 32; b++) begin
      logic [31:0] m;
      wr(4'd0, 32'(b - 1));
      m = (b == 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
      chk("R1 bytes", {29'b0, word_bytes}, (b <= 8) ? 32'd1 : (b <= 16) ? 32'd2 : 32'd4);
      chk("R2 justify", rx_word, rx_raw & m);
    end

    wr(4'd10, 32'h0F00);  // mask service/done from irq

    // R4 R6 R3: FIFO-mode input, block register ignored
    for (int n = 1; n <= 4; n++) begin
      wr(4'd1, 32'h0); wr(4'd2, 32'(n)); wr(4'd4, 32'd3); wr(4'd6, 32'hF00);
      for (int k = 1; k <= n; k++) begin
        ipush();
        chk("R4 in done", {31'b0, op_flags[11]}, {31'b0, k == n});
        chk("R6 in svc", {31'b0, op_flags[9]}, 32'd1);
        wr(4'd6, 32'h200);
        ipop();
      end
      wr(4'd6, 32'hF00);
      ipush();
      chk("R4 no refire", {31'b0, op_flags[11]}, 32'd0);
      ipop();
    end

    // R3: FIFO mode with zero FIFO count never completes from block count
    wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd4, 32'd2); wr(4'd6, 32'hF00);
    for (int k = 0; k < 3; k++) begin ipush(); ipop(); end
    chk("R3 unused count", {31'b0, op_flags[11]}, 32'd0);

    // R5 R4 R3: block-mode input
    wr(4'd1, 32'h1000); wr(4'd4, 32'd10); wr(4'd2, 32'd5); wr(4'd6, 32'hF00);
    for (int k = 1; k <= 10; k++) begin
      ipush();
      chk("R5 in blk svc", {31'b0, op_flags[9]}, {31'b0, (k % 4) == 0});
      chk("R3 R4 in blk done", {31'b0, op_flags[11]}, {31'b0, k == 10});
      wr(4'd6, 32'hF00);
      ipop();
    end

    // R4 R6: FIFO-mode output
    wr(4'd1, 32'h0); wr(4'd3, 32'd3); wr(4'd6, 32'hF00);
    for (int k = 0; k < 3; k++) opush();
    chk("R6 push no svc", {31'b0, op_flags[8]}, 32'd0);
    for (int k = 1; k <= 3; k++) begin
      opop();
      chk("R4 out done", {31'b0, op_flags[10]}, {31'b0, k == 3});
      chk("R6 out svc empty", {31'b0, op_flags[8]}, {31'b0, k == 3});
    end

    // R5 R7: block-mode output to full depth
    wr(4'd1, 32'h400); wr(4'd5, 32'd8); wr(4'd6, 32'hF00);
    for (int k = 0; k < DEPTH; k++) opush();
    chk("R7 out full", {31'b0, op_flags[6]}, 32'd1);
    chk("R7 out nempty", {31'b0, op_flags[4]}, 32'd1);
    for (int k = 1; k <= DEPTH; k++) begin
      opop();
      chk("R5 out blk svc", {31'b0, op_flags[8]}, {31'b0, (k % 4) == 0});
      chk("R4 out blk done", {31'b0, op_flags[10]}, {31'b0, k == 8});
      wr(4'd6, 32'hF00);
    end
    chk("R7 out empty", {31'b0, op_flags[4]}, 32'd0);

    // R7: input live bits
    chk("R7 in empty", {30'b0, op_flags[7], op_flags[5]}, 32'd0);
    for (int k = 0; k < DEPTH - 1; k++) ipush();
    chk("R7 in not full", {30'b0, op_flags[7], op_flags[5]}, 32'd1);
    ipush();
    chk("R7 in full", {30'b0, op_flags[7], op_flags[5]}, 32'd3);

    // R8: each error source
    chk("R8 clean", {24'b0, err_flags}, 32'h00);
    ipush();
    chk("R8 in over", {24'b0, err_flags}, 32'h04);
    for (int k = 0; k < DEPTH; k++) ipop();
    ipop();
    chk("R8 in under", {24'b0, err_flags}, 32'h14);
    opop();
    chk("R8 out under", {24'b0, err_flags}, 32'h1C);
    for (int k = 0; k < DEPTH; k++) opush();
    chk("R8 no err at fill", {24'b0, err_flags}, 32'h1C);
    opush();
    chk("R8 out over", {24'b0, err_flags}, 32'h3C);
    cycw(0, 0, 0, 0, 1, 0, 0, 4'd0, 32'd0);
    chk("R8 sclk over", {30'b0, ser_flags}, 32'd2);
    cycw(0, 0, 0, 0, 0, 1, 0, 4'd0, 32'd0);
    chk("R8 sclk under", {30'b0, ser_flags}, 32'd3);

    // R10: enables and mask
    wr(4'd6, 32'hF00);
    chk("R10 no enable", {31'b0, irq}, 32'd0);
    wr(4'd9, 32'h04);
    chk("R10 err enable", {31'b0, irq}, 32'd1);
    wr(4'd9, 32'h01);
    chk("R10 ser enable", {31'b0, irq}, 32'd1);
    wr(4'd9, 32'h00);
    wr(4'd10, 32'h0);
    chk("R10 unmasked idle", {31'b0, irq}, 32'd0);
    ipush();
    chk("R10 svc unmasked", {31'b0, irq}, 32'd1);
    wr(4'd10, 32'h0200);
    chk("R10 svc masked", {31'b0, irq}, 32'd0);
    ipop();

    // R9: write-one-to-clear
    wr(4'd7, 32'h0C);
    chk("R9 partial clear", {24'b0, err_flags}, 32'h30);
    wr(4'd7, 32'h00);
    chk("R9 zero write", {24'b0, err_flags}, 32'h30);
    cycw(0, 0, 1, 0, 0, 0, 1, 4'd7, 32'h20);
    chk("R9 set wins", {24'b0, err_flags}, 32'h30);
    wr(4'd8, 32'h3);
    chk("R9 ser clear", {30'b0, ser_flags}, 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule